// File: doc/BRIEF.md
# Reloadable Down-Counter Timer

A timer peripheral with one register port and one active-high interrupt line. Software writes a load value as two words, then a control word that starts the count and picks periodic or single-shot operation and a 32-bit or 64-bit count. The count runs down by one each clock. When it expires, a sticky raw status bit is set. That bit is gated by an interrupt enable to form the masked status and the interrupt line. Software writes a clear bit to acknowledge the event.

The register port is a plain word-wide bus. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational from `addr`. The bus carries single register accesses, not a data stream, so there is no valid/ready handshake and no back-pressure. The live count and a shadow copy can both be read. Reading the low shadow word captures the high shadow word, which makes a two-word read coherent.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every register reads 0, the timer is stopped and `irq` is low.
- R2: Register offsets are 0x00 load low, 0x04 load high, 0x08 count low, 0x0C count high, 0x10 control, 0x14 interrupt, 0x18 shadow low and 0x1C shadow high. Control bits are: bit 0 periodic, bit 1 run, bit 16 wide. A control write that sets run while the timer is stopped loads the count in that edge. A wide start loads {load high, load low}. A narrow start loads only the low word, and the count high word then reads 0.
- R3: While running, the count falls by one per clock and borrows across the 32-bit word boundary. Expiry is the edge where the count goes from 1 to 0. A start with a load value of 0 expires in the start edge itself.
- R4: In periodic mode, an expiry reloads the count from the load registers and counting continues.
- R5: In single-shot mode, an expiry leaves the count at 0 and clears the run bit, so control then reads 0 in bit 1.
- R6: Each expiry sets raw status (interrupt bit 1). Raw status stays set until a write with interrupt bit 3 set. If an expiry and a clear fall in the same edge, the expiry wins.
- R7: Interrupt bit 0 is a writable enable. Bit 2 reads raw AND enable, and `irq` is high exactly when that bit is set.
- R8: The shadow copy takes the value the count had before each edge at which the timer is running. It holds while the timer is stopped. Reading shadow low captures shadow high for the next read of offset 0x1C.
- R9: A write to the load registers while the timer is running does not change the current count. It takes effect at the next reload or start.
- R10: A control write with run clear stops the count, and the count then holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, used for shadow capture |
| addr | input | 5 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Masked interrupt, active high |

## Verification
Read data is due in the same cycle as the address, so the bench samples it 1 ns after it drives the address on the falling edge. A write acts at the next rising edge. An expiry is visible on `irq` and in the status right after the edge where the count steps from 1 to 0, which is load-value edges after the starting write. The shadow value lags the live count by one edge. A bench reference model steps once per rising edge with the same inputs the design saw. Every read and the `irq` line are compared against it at the falling edge that follows.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int OFS_LD_LO  = 0;
  localparam int OFS_LD_HI  = 4;
  localparam int OFS_CNT_LO = 8;
  localparam int OFS_CNT_HI = 12;
  localparam int OFS_CTRL   = 16;
  localparam int OFS_IRQ    = 20;
  localparam int OFS_SHD_LO = 24;
  localparam int OFS_SHD_HI = 28;

  localparam int CB_PERIODIC = 0;
  localparam int CB_RUN      = 1;
  localparam int CB_WIDE     = 16;

  localparam int IB_EN  = 0;
  localparam int IB_RAW = 1;
  localparam int IB_MSK = 2;
  localparam int IB_CLR = 3;
endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              oneshot_done,
  output logic              start,
  output logic              run_q,
  output logic              periodic_q,
  output logic              wide_q,
  output logic              per_pick,
  output logic [CNT_W-1:0]  ld_pick,
  output logic [DATA_W-1:0] ld_lo_q,
  output logic [DATA_W-1:0] ld_hi_q,
  output logic              irq_en_q,
  output logic              clr_pulse
);
  logic ctrl_wr, irq_wr, wide_sel;

  always_comb begin
    ctrl_wr   = wr_en && (addr == ADDR_W'(OFS_CTRL));
    irq_wr    = wr_en && (addr == ADDR_W'(OFS_IRQ));
    start     = ctrl_wr && wr_data[CB_RUN] && !run_q;
    wide_sel  = start ? wr_data[CB_WIDE] : wide_q;
    per_pick  = start ? wr_data[CB_PERIODIC] : periodic_q;
    ld_pick   = {ld_hi_q & {DATA_W{wide_sel}}, ld_lo_q};
    clr_pulse = irq_wr && wr_data[IB_CLR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_lo_q    <= '0;
      ld_hi_q    <= '0;
      run_q      <= 1'b0;
      periodic_q <= 1'b0;
      wide_q     <= 1'b0;
      irq_en_q   <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_W'(OFS_LD_LO)) ld_lo_q <= wr_data;
      if (wr_en && addr == ADDR_W'(OFS_LD_HI)) ld_hi_q <= wr_data;
      if (irq_wr) irq_en_q <= wr_data[IB_EN];
      if (ctrl_wr) begin
        run_q      <= wr_data[CB_RUN] && !(start && oneshot_done);
        periodic_q <= wr_data[CB_PERIODIC];
        wide_q     <= wr_data[CB_WIDE];
      end else if (oneshot_done) begin
        run_q <= 1'b0;
      end
    end
  end

  // R5: a single-shot expiry halts the timer unless software rewrites control
  a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_done && (!ctrl_wr || start)) |=> !run_q);
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run_q,
  input  logic             per_pick,
  input  logic [CNT_W-1:0] ld_pick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire,
  output logic             oneshot_done
);
  always_comb begin
    if (start) expire = (ld_pick == '0);
    else       expire = run_q && (cnt_q <= CNT_W'(1));
    oneshot_done = expire && !per_pick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= ld_pick;
    end else if (run_q) begin
      if (cnt_q <= CNT_W'(1)) cnt_q <= per_pick ? ld_pick : '0;
      else                    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R2: a start loads the selected load value
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == $past(ld_pick)));
  // R3: one step down per running clock
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4: periodic expiry reloads
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && expire && per_pick) |=> (cnt_q == $past(ld_pick)));
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_pulse,
  output logic raw_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         raw_q <= 1'b0;
    else if (expire)    raw_q <= 1'b1;
    else if (clr_pulse) raw_q <= 1'b0;
  end

  // R6: set by expiry, sticky, cleared only by a clear without expiry
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_pulse) |=> raw_q);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !expire) |=> !raw_q);
endmodule

// File: rtl/tmr_shadow.sv
`timescale 1ns/1ps
module tmr_shadow #(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              lo_rd,
  output logic [CNT_W-1:0]  shd_q,
  output logic [DATA_W-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_q  <= '0;
      hold_q <= '0;
    end else begin
      if (run_q) shd_q  <= cnt_q;
      if (lo_rd) hold_q <= shd_q[CNT_W-1:DATA_W];
    end
  end

  // R8: the shadow copy holds while the timer is stopped
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(shd_q));
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic              start, run_q, periodic_q, wide_q, per_pick;
  logic              irq_en_q, clr_pulse, expire, oneshot_done, raw_q;
  logic [CNT_W-1:0]  ld_pick, cnt_q, shd_q;
  logic [DATA_W-1:0] ld_lo_q, ld_hi_q, hold_q;
  logic              lo_rd;

  assign lo_rd = rd_en && (addr == ADDR_W'(OFS_SHD_LO));
  assign irq   = raw_q && irq_en_q;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .oneshot_done(oneshot_done), .start(start), .run_q(run_q),
    .periodic_q(periodic_q), .wide_q(wide_q), .per_pick(per_pick),
    .ld_pick(ld_pick), .ld_lo_q(ld_lo_q), .ld_hi_q(ld_hi_q),
    .irq_en_q(irq_en_q), .clr_pulse(clr_pulse)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .start(start), .run_q(run_q),
    .per_pick(per_pick), .ld_pick(ld_pick), .cnt_q(cnt_q),
    .expire(expire), .oneshot_done(oneshot_done)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_pulse(clr_pulse),
    .raw_q(raw_q)
  );

  tmr_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .cnt_q(cnt_q), .lo_rd(lo_rd),
    .shd_q(shd_q), .hold_q(hold_q)
  );

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_W'(OFS_LD_LO):  rd_data = ld_lo_q;
      ADDR_W'(OFS_LD_HI):  rd_data = ld_hi_q;
      ADDR_W'(OFS_CNT_LO): rd_data = cnt_q[DATA_W-1:0];
      ADDR_W'(OFS_CNT_HI): rd_data = cnt_q[CNT_W-1:DATA_W];
      ADDR_W'(OFS_CTRL): begin
        rd_data[CB_PERIODIC] = periodic_q;
        rd_data[CB_RUN]      = run_q;
        rd_data[CB_WIDE]     = wide_q;
      end
      ADDR_W'(OFS_IRQ): begin
        rd_data[IB_EN]  = irq_en_q;
        rd_data[IB_RAW] = raw_q;
        rd_data[IB_MSK] = raw_q && irq_en_q;
      end
      ADDR_W'(OFS_SHD_LO): rd_data = shd_q[DATA_W-1:0];
      ADDR_W'(OFS_SHD_HI): rd_data = hold_q;
      default:             rd_data = '0;
    endcase
  end

  // R7: the line follows raw status while enabled and stays low otherwise
  a_r7_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq);
endmodule

// File: tb/test_tmr_unit.sv
`timescale 1ns/1ps
module test_tmr_unit;
  localparam int A_LD_LO = 0, A_LD_HI = 4, A_CNT_LO = 8, A_CNT_HI = 12;
  localparam int A_CTRL = 16, A_IRQ = 20, A_SHD_LO = 24, A_SHD_HI = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] m_lo, m_hi, m_hold;
  logic [63:0] m_cnt, m_sh;
  logic m_en, m_per, m_wide, m_ie, m_raw;

  always #2.5 clk = ~clk;

  tmr_unit i_tmr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] v;
    v = '0;
    case (a)
      A_LD_LO:  v = m_lo;
      A_LD_HI:  v = m_hi;
      A_CNT_LO: v = m_cnt[31:0];
      A_CNT_HI: v = m_cnt[63:32];
      A_CTRL:   begin v[0] = m_per; v[1] = m_en; v[16] = m_wide; end
      A_IRQ:    begin v[0] = m_ie; v[1] = m_raw; v[2] = m_raw & m_ie; end
      A_SHD_LO: v = m_sh[31:0];
      A_SHD_HI: v = m_hold;
      default:  v = '0;
    endcase
    return v;
  endfunction

  function automatic void m_step();
    logic cw, st, wsel, psel, ev, done;
    logic [63:0] ld;
    cw   = wr_en && addr == 5'(A_CTRL);
    st   = cw && wr_data[1] && !m_en;
    wsel = st ? wr_data[16] : m_wide;
    psel = st ? wr_data[0] : m_per;
    ld   = {wsel ? m_hi : 32'h0, m_lo};
    ev   = 1'b0;
    if (rd_en && addr == 5'(A_SHD_LO)) m_hold = m_sh[63:32];
    if (m_en) m_sh = m_cnt;
    if (st) begin
      m_cnt = ld;
      ev = (ld == 64'h0);
    end else if (m_en) begin
      if (m_cnt <= 64'h1) begin
        ev = 1'b1;
        m_cnt = psel ? ld : 64'h0;
      end else m_cnt = m_cnt - 64'h1;
    end
    done = ev && !psel;
    if (cw) begin
      m_en = wr_data[1] && !(st && done);
      m_per = wr_data[0];
      m_wide = wr_data[16];
    end else if (done) m_en = 1'b0;
    if (ev) m_raw = 1'b1;
    else if (wr_en && addr == 5'(A_IRQ) && wr_data[3]) m_raw = 1'b0;
    if (wr_en && addr == 5'(A_IRQ)) m_ie = wr_data[0];
    if (wr_en && addr == 5'(A_LD_LO)) m_lo = wr_data;
    if (wr_en && addr == 5'(A_LD_HI)) m_hi = wr_data;
  endfunction

  task automatic cycle();
    @(posedge clk);
    m_step();
    @(negedge clk);
    chk("R7 irq line", {63'h0, irq}, {63'h0, m_raw & m_ie});
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 5'(a); wr_data = d; wr_en = 1'b1;
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input int a, input logic [31:0] exp, input string tag);
    addr = 5'(a); rd_en = 1'b1;
    #1;
    chk(tag, {32'h0, rd_data}, {32'h0, exp});
    chk({tag, " model"}, {32'h0, rd_data}, {32'h0, m_read(a)});
    cycle();
    rd_en = 1'b0;
  endtask

  task automatic rd_m(input int a, input string tag);
    addr = 5'(a); rd_en = 1'b1;
    #1;
    chk(tag, {32'h0, rd_data}, {32'h0, m_read(a)});
    cycle();
    rd_en = 1'b0;
  endtask

  function automatic string tag_of(input int a);
    case (a)
      A_LD_LO, A_LD_HI:   return "R9 load readback";
      A_CNT_LO, A_CNT_HI: return "R3 live count";
      A_CTRL:             return "R5 control";
      A_IRQ:              return "R6 status";
      default:            return "R8 shadow";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_lo = '0; m_hi = '0; m_hold = '0; m_cnt = '0; m_sh = '0;
    m_en = 0; m_per = 0; m_wide = 0; m_ie = 0; m_raw = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", {63'h0, irq}, 64'h0);
    for (int a = 0; a < 32; a += 4) rd_exp(a, 32'h0, "R1 reset register");

    // R2/R3/R5/R6: narrow single-shot of 5
    wr(A_LD_LO, 32'd5);
    wr(A_LD_HI, 32'd7);
    wr(A_IRQ, 32'h1);
    wr(A_CTRL, 32'h2);
    rd_exp(A_CNT_LO, 32'd5, "R2 start loads low word");
    rd_exp(A_CNT_LO, 32'd4, "R3 decrement");
    rd_exp(A_CNT_HI, 32'd0, "R2 narrow high word");
    cycle();
    chk("R6 no event before expiry", {63'h0, irq}, 64'h0);
    cycle();
    chk("R6 expiry raises irq", {63'h0, irq}, 64'h1);
    rd_exp(A_CTRL, 32'h0, "R5 run bit cleared");
    rd_exp(A_IRQ, 32'h7, "R7 status bits");
    rd_exp(A_CNT_LO, 32'h0, "R5 count stays 0");
    repeat (3) cycle();
    rd_exp(A_CNT_LO, 32'h0, "R5 still stopped");

    // R7 masking and R6 clear
    wr(A_IRQ, 32'h0);
    chk("R7 masked line low", {63'h0, irq}, 64'h0);
    rd_exp(A_IRQ, 32'h2, "R7 raw kept while masked");
    wr(A_IRQ, 32'h9);
    rd_exp(A_IRQ, 32'h1, "R6 clear");

    // R3/R6: load 0 periodic expires every cycle, expiry beats clear
    wr(A_LD_LO, 32'd0);
    wr(A_CTRL, 32'h3);
    chk("R3 zero load expires at start", {63'h0, irq}, 64'h1);
    wr(A_IRQ, 32'h9);
    rd_exp(A_IRQ, 32'h7, "R6 expiry beats clear");
    wr(A_CTRL, 32'h0);
    wr(A_IRQ, 32'h9);
    rd_exp(A_IRQ, 32'h1, "R6 clear after stop");

    // R4/R9/R10 periodic reload with load rewritten mid-run
    wr(A_LD_LO, 32'd4);
    wr(A_CTRL, 32'h3);
    wr(A_LD_LO, 32'd9);
    rd_exp(A_CNT_LO, 32'd3, "R9 running count unaffected");
    cycle();
    cycle();
    rd_exp(A_CNT_LO, 32'd9, "R4 reload with new value");
    wr(A_CTRL, 32'h0);
    rd_exp(A_CNT_LO, 32'd7, "R10 stop holds count");
    rd_exp(A_CNT_LO, 32'd7, "R10 count still held");
    rd_exp(A_SHD_LO, 32'd8, "R8 shadow frozen");
    rd_exp(A_SHD_LO, 32'd8, "R8 shadow still frozen");
    wr(A_IRQ, 32'h9);

    // R2/R3 wide count with borrow
    wr(A_LD_HI, 32'd1);
    wr(A_LD_LO, 32'd2);
    wr(A_CTRL, 32'h0001_0002);
    rd_exp(A_CNT_HI, 32'd1, "R2 wide high word");
    rd_exp(A_CNT_LO, 32'd1, "R3 wide decrement");
    rd_exp(A_CNT_LO, 32'd0, "R3 wide low zero");
    rd_exp(A_CNT_HI, 32'd0, "R3 borrow into high");
    rd_m(A_SHD_LO, "R8 shadow low");
    rd_m(A_SHD_HI, "R8 shadow high captured");
    wr(A_CTRL, 32'h0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      d = '0;
      case (op)
        0: wr(A_LD_LO, $urandom_range(0, 12));
        1: wr(A_LD_HI, $urandom_range(0, 2));
        2: begin
          if (!m_en) begin
            d[1] = 1'b1; d[0] = 1'($urandom_range(0, 1)); d[16] = 1'($urandom_range(0, 1));
          end
          wr(A_CTRL, d);
        end
        3: begin
          d[0] = 1'($urandom_range(0, 1)); d[3] = 1'($urandom_range(0, 1));
          wr(A_IRQ, d);
        end
        4, 5, 6, 7: begin
          int a;
          a = 4 * $urandom_range(0, 7);
          rd_m(a, tag_of(a));
        end
        default: cycle();
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule